// File: doc/BRIEF.md
# Dual-Section Configurable Ripple Counter

This block is a four-bit counter built from two sections. One is a single toggle stage producing `q[0]`; the other is a three-bit section producing `q[3:1]`. A build-time parameter fixes the length of the three-bit section at 5 (decade variant), 6 (divide-by-twelve variant) or 8 (binary variant). Each section has its own count strobe, `cka` for the toggle stage and `ckb` for the three-bit section. A section advances when its strobe goes from high to low, and strobes are sampled on the system clock `clk`.

A two-bit `mode` input selects how the sections are wired together. `2'b00` runs them independently, and `2'b11` does the same. `2'b01` lets a falling `q[0]` advance the three-bit section, so counting on `cka` covers the full 10, 12 or 16 states. `2'b10` lets the three-bit section's wrap toggle `q[0]`, so counting on `ckb` gives a symmetric square wave on `q[0]` at one tenth of the strobe rate in the decade variant. In the cascaded modes the driven section advances in the same system cycle as the driving one, with no ripple delay.

The gated zero reset clears all outputs only when every `zero_req` bit is high. In the decade variant, the gated preset loads nine (`q = 4'b1001`) only when every `nine_req` bit is high, and it wins over zero reset. Both act at the clock edge that samples them, and both override counting.

The toggle stage has two named states, LOW and HIGH. The only transition is a toggle on advance; clear forces LOW and preset forces HIGH. The three-bit section has states TC0 to TC7. Its transitions are: advance to the next state, wrap from the last state (TC4, TC5 or TC7 by variant) to TC0, clear to TC0, and preset to TC4.

Top module: `ripple_counter4`

## Requirements
- R1: While `rst_n` is low, `q` is `4'b0000`.
- R2: The three-bit section counts `q[3:1]` as binary 0 up to SECTION_LEN-1 and then wraps to 0. SECTION_LEN is 5, 6 or 8.
- R3: In mode `2'b00`, each falling `cka` toggles `q[0]`, and each falling `ckb` advances `q[3:1]` by one step of R2. Each result is visible after the clock edge that samples the low strobe level.
- R4: A rising strobe or a strobe held at one level changes nothing. Only a sampled high-to-low change counts.
- R5: In mode `2'b01`, a falling `cka` toggles `q[0]`. When `q[0]` was 1, the same edge also advances `q[3:1]`. The value `{q[3:1],q[0]}` therefore runs through 2×SECTION_LEN states and returns to zero.
- R6: In mode `2'b10`, a falling `ckb` advances `q[3:1]`. When `q[3:1]` wraps from SECTION_LEN-1 to 0, the same edge toggles `q[0]`. In the decade variant, `q[0]` is high for 5 and low for 5 of every 10 strobes.
- R7: When both `zero_req` bits are high, `q` becomes `4'b0000` at the next edge. A single high bit has no effect.
- R8: In the decade variant, both `nine_req` bits high make `q` equal `4'b1001` at the next edge, even while `zero_req` is also fully asserted. In the other variants `nine_req` has no effect, and a single high bit has none in any variant.
- R9: Mode `2'b11` behaves exactly as mode `2'b00`.
- R10: In mode `2'b01` a falling `ckb` changes nothing, and in mode `2'b10` a falling `cka` changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cka | input | 1 | Count strobe for the toggle stage |
| ckb | input | 1 | Count strobe for the three-bit section |
| mode | input | 2 | Section wiring: 00 split, 01 cascade, 10 bi-quinary, 11 split |
| zero_req | input | 2 | Gated zero-reset requests, effective when all are high |
| nine_req | input | 2 | Gated preset-to-nine requests, decade variant only |
| q | output | 4 | Count outputs; q[0] is the toggle stage and q[3:1] the three-bit section |

## Verification
Both sections drive `q` straight from their state registers. A wrong state therefore appears at the ports right after the strobe that produced it, one system clock edge after the strobe is sampled low. A three-bit section stuck in an unused state, or one that wraps at the wrong point, shows a value of SECTION_LEN or higher on `q[3:1]`, or a cascade period other than 10, 12 or 16. A wrong wiring in the cascaded modes makes `q` step by the wrong amount on the very next strobe. Because of this, the bench compares `q` against a reference after every single strobe, in all three variants side by side.

// File: rtl/rctr_pkg.sv
package rctr_pkg;

    typedef enum logic [1:0] {
        LINK_SPLIT     = 2'b00,
        LINK_CASCADE   = 2'b01,
        LINK_BIQUINARY = 2'b10,
        LINK_SPLIT_ALT = 2'b11
    } link_e;

    typedef enum logic {
        HALF_LOW  = 1'b0,
        HALF_HIGH = 1'b1
    } half_state_e;

    typedef enum logic [2:0] {
        TC0 = 3'd0, TC1 = 3'd1, TC2 = 3'd2, TC3 = 3'd3,
        TC4 = 3'd4, TC5 = 3'd5, TC6 = 3'd6, TC7 = 3'd7
    } tri_state_e;

endpackage

// File: rtl/strobe_fall.sv
module strobe_fall (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= strobe;
    end

    assign fall = prev_q & ~strobe;

    // a fall can only be reported when the strobe had been seen high
    assert_fall_after_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> $past(strobe));
endmodule

// File: rtl/half_stage.sv
module half_stage
    import rctr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic clear,
    input  logic preset,
    output logic q
);
    half_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HALF_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (preset) begin
            state_d = HALF_HIGH;
        end else if (clear) begin
            state_d = HALF_LOW;
        end else if (adv) begin
            unique case (state_q)
                HALF_LOW:  state_d = HALF_HIGH;
                HALF_HIGH: state_d = HALF_LOW;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            HALF_LOW:  q = 1'b0;
            HALF_HIGH: q = 1'b1;
        endcase
    end

    assert_half_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clear && !preset) |=> (q != $past(q)));
    assert_half_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clear && !preset) |=> $stable(q));
endmodule

// File: rtl/tri_stage.sv
module tri_stage
    import rctr_pkg::*;
#(
    parameter int SECTION_LEN = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic       clear,
    input  logic       preset,
    output logic [2:0] bits,
    output logic       at_last
);
    localparam logic [2:0] LAST_IDX   = 3'(SECTION_LEN - 1);
    localparam logic [2:0] PRESET_IDX = 3'd4;

    tri_state_e state_q, state_d, succ;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TC0;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            TC0: succ = TC1;
            TC1: succ = TC2;
            TC2: succ = TC3;
            TC3: succ = TC4;
            TC4: succ = TC5;
            TC5: succ = TC6;
            TC6: succ = TC7;
            TC7: succ = TC0;
        endcase
        if (state_q >= tri_state_e'(LAST_IDX)) succ = TC0;
    end

    always_comb begin
        state_d = state_q;
        if (preset)      state_d = tri_state_e'(PRESET_IDX);
        else if (clear)  state_d = TC0;
        else if (adv)    state_d = succ;
    end

    always_comb begin
        unique case (state_q)
            TC0: bits = 3'd0;
            TC1: bits = 3'd1;
            TC2: bits = 3'd2;
            TC3: bits = 3'd3;
            TC4: bits = 3'd4;
            TC5: bits = 3'd5;
            TC6: bits = 3'd6;
            TC7: bits = 3'd7;
        endcase
    end

    assign at_last = (state_q == tri_state_e'(LAST_IDX));

    assert_tri_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bits <= LAST_IDX);
    assert_tri_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && at_last && !clear && !preset) |=> (bits == 3'd0));
    assert_tri_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !at_last && !clear && !preset) |=> (bits == $past(bits) + 3'd1));
endmodule

// File: rtl/ripple_counter4.sv
module ripple_counter4
    import rctr_pkg::*;
#(
    parameter int SECTION_LEN = 5,
    parameter int GATE_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cka,
    input  logic              ckb,
    input  logic [1:0]        mode,
    input  logic [GATE_W-1:0] zero_req,
    input  logic [GATE_W-1:0] nine_req,
    output logic [3:0]        q
);
    localparam bit HAS_NINE = (SECTION_LEN == 5);
    localparam int N_STROBE = 2;

    logic [N_STROBE-1:0] strobes, falls;
    logic                qa, tri_last, qa_adv, tri_adv;
    logic                zero_all, nine_all, clear_all, override;
    logic [2:0]          tri_bits;
    link_e               link;

    assign strobes = {ckb, cka};

    for (genvar g = 0; g < N_STROBE; g++) begin : g_edge
        strobe_fall u_fall (
            .clk    (clk),
            .rst_n  (rst_n),
            .strobe (strobes[g]),
            .fall   (falls[g])
        );
    end

    assign link      = link_e'(mode);
    assign zero_all  = &zero_req;
    assign nine_all  = HAS_NINE && (&nine_req);
    assign clear_all = zero_all & ~nine_all;
    assign override  = zero_all | nine_all;

    always_comb begin
        qa_adv  = 1'b0;
        tri_adv = 1'b0;
        unique case (link)
            LINK_SPLIT, LINK_SPLIT_ALT: begin
                qa_adv  = falls[0];
                tri_adv = falls[1];
            end
            LINK_CASCADE: begin
                qa_adv  = falls[0];
                tri_adv = falls[0] & qa;
            end
            LINK_BIQUINARY: begin
                tri_adv = falls[1];
                qa_adv  = falls[1] & tri_last;
            end
        endcase
    end

    half_stage u_half (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (qa_adv),
        .clear  (clear_all),
        .preset (nine_all),
        .q      (qa)
    );

    tri_stage #(.SECTION_LEN(SECTION_LEN)) u_tri (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (tri_adv),
        .clear   (clear_all),
        .preset  (nine_all),
        .bits    (tri_bits),
        .at_last (tri_last)
    );

    assign q = {tri_bits, qa};

    assert_zero_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (&zero_req && !(HAS_NINE && &nine_req)) |=> (q == 4'b0000));
    assert_nine_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_NINE && &nine_req) |=> (q == 4'b1001));
    assert_cascade_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && !override && falls[0] && q[0]) |=> (q[0] == 1'b0 && q[3:1] != $past(q[3:1])));
    assert_cascade_ignore_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && !override && !falls[0]) |=> $stable(q));
    assert_biq_ignore_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && !override && !falls[1]) |=> $stable(q));
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |-> (q == 4'b0000));
endmodule

// File: tb/sim_ripple_counter4.sv
module sim_ripple_counter4;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cka = 1'b0, ckb = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [1:0] zero_req = 2'b00, nine_req = 2'b00;
    logic [3:0] q0, q1, q2;

    int checks = 0, fails = 0;
    int lens [3] = '{5, 6, 8};
    int ref_tri [3];
    bit ref_qa [3];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ripple_counter4 #(.SECTION_LEN(5)) u0 (.clk(clk), .rst_n(rst_n), .cka(cka), .ckb(ckb),
        .mode(mode), .zero_req(zero_req), .nine_req(nine_req), .q(q0));
    ripple_counter4 #(.SECTION_LEN(6)) u1 (.clk(clk), .rst_n(rst_n), .cka(cka), .ckb(ckb),
        .mode(mode), .zero_req(zero_req), .nine_req(nine_req), .q(q1));
    ripple_counter4 #(.SECTION_LEN(8)) u2 (.clk(clk), .rst_n(rst_n), .cka(cka), .ckb(ckb),
        .mode(mode), .zero_req(zero_req), .nine_req(nine_req), .q(q2));

    function automatic logic [3:0] dut_q(int u);
        return (u == 0) ? q0 : (u == 1) ? q1 : q2;
    endfunction

    task automatic check_one(string tag, int u, logic [3:0] exp);
        checks++;
        if (dut_q(u) !== exp) begin
            fails++;
            $display("FAIL %s variant u%0d: q=%b expected %b", tag, u, dut_q(u), exp);
        end
    endtask

    task automatic check_all(string tag);
        for (int u = 0; u < 3; u++)
            check_one(tag, u, {3'(ref_tri[u]), ref_qa[u]});
    endtask

    task automatic model_clear();
        for (int u = 0; u < 3; u++) begin ref_tri[u] = 0; ref_qa[u] = 1'b0; end
    endtask

    task automatic model_a();
        for (int u = 0; u < 3; u++) begin
            if (mode == 2'b01 && ref_qa[u]) ref_tri[u] = (ref_tri[u] + 1) % lens[u];
            if (mode != 2'b10) ref_qa[u] = ~ref_qa[u];
        end
    endtask

    task automatic model_b();
        for (int u = 0; u < 3; u++) begin
            if (mode == 2'b10 && ref_tri[u] == lens[u] - 1) ref_qa[u] = ~ref_qa[u];
            if (mode != 2'b01) ref_tri[u] = (ref_tri[u] + 1) % lens[u];
        end
    endtask

    // strobe high for one cycle, then low; result visible after the edge that samples low
    task automatic pulse_a(string tag);
        @(negedge clk) cka = 1'b1;
        @(negedge clk) cka = 1'b0;
        @(negedge clk);
        model_a();
        check_all(tag);
    endtask

    task automatic pulse_b(string tag);
        @(negedge clk) ckb = 1'b1;
        @(negedge clk) ckb = 1'b0;
        @(negedge clk);
        model_b();
        check_all(tag);
    endtask

    task automatic apply_zero(logic [1:0] z, logic [1:0] n);
        @(negedge clk) begin zero_req = z; nine_req = n; end
        @(negedge clk) begin zero_req = 2'b00; nine_req = 2'b00; end
    endtask

    task automatic t_reset();
        @(negedge clk);
        for (int u = 0; u < 3; u++) check_one("R1", u, 4'b0000);
        @(negedge clk) rst_n = 1'b1;
        model_clear();
    endtask

    task automatic t_split();
        mode = 2'b00;
        for (int i = 0; i < 3; i++) pulse_a("R3");
        for (int i = 0; i < 9; i++) pulse_b("R2");
    endtask

    task automatic t_edges();
        @(negedge clk) cka = 1'b1;
        @(negedge clk) ckb = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R4");
        @(negedge clk) begin cka = 1'b0; ckb = 1'b0; end
        @(negedge clk);
        model_a(); model_b();
        check_all("R4");
        repeat (3) @(negedge clk);
        check_all("R4");
    endtask

    task automatic t_zero();
        apply_zero(2'b01, 2'b00);
        check_all("R7");
        apply_zero(2'b10, 2'b00);
        check_all("R7");
        apply_zero(2'b11, 2'b00);
        model_clear();
        check_all("R7");
    endtask

    task automatic t_cascade();
        mode = 2'b01;
        apply_zero(2'b11, 2'b00);
        model_clear();
        for (int i = 0; i < 17; i++) pulse_a("R5");
        pulse_b("R10");
    endtask

    task automatic t_biquinary();
        int highs = 0;
        mode = 2'b10;
        apply_zero(2'b11, 2'b00);
        model_clear();
        for (int i = 0; i < 10; i++) begin
            pulse_b("R6");
            if (q0[0]) highs++;
        end
        checks++;
        if (highs != 5) begin
            fails++;
            $display("FAIL R6 decade duty: high=%0d expected 5", highs);
        end
        checks++;
        if (q0 !== 4'b0000) begin
            fails++;
            $display("FAIL R6 decade period: q=%b expected 0000", q0);
        end
        for (int i = 0; i < 7; i++) pulse_b("R6");
        pulse_a("R10");
    endtask

    task automatic t_nine();
        mode = 2'b00;
        apply_zero(2'b11, 2'b00);
        model_clear();
        pulse_b("R3");
        apply_zero(2'b00, 2'b01);
        check_all("R8");
        apply_zero(2'b00, 2'b11);
        ref_tri[0] = 4; ref_qa[0] = 1'b1;
        check_all("R8");
        pulse_a("R3");
        apply_zero(2'b11, 2'b11);
        model_clear();
        ref_tri[0] = 4; ref_qa[0] = 1'b1;
        check_all("R8");
    endtask

    task automatic t_mode3();
        mode = 2'b11;
        for (int i = 0; i < 2; i++) pulse_a("R9");
        for (int i = 0; i < 4; i++) pulse_b("R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_split();
        t_edges();
        t_zero();
        t_cascade();
        t_biquinary();
        t_nine();
        t_mode3();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule